// File: doc/BRIEF.md
# Address-Triggered Debug Watchdog Monitor

This block sits beside a CPU bus and watches every qualified address access. A small table of tagged addresses, written through a simple programming port, attaches an action code to each tag. When a strobed access hits a valid tag, the block acts on that code. It can emit a one-cycle marker pulse, timed at the access, which a display overlay places at the current raster position. It can switch a trace-logging enable on or off. It can also arm, feed or disarm a line-counting watchdog.

The watchdog counts line ticks rather than clock cycles. This lets software that polls a timer during blanking set a budget in scan lines. A poll loop that overruns that budget by a single line then raises a trap flag. The trap stays set until it is cleared explicitly. The trace memory and the overlay rendering sit outside this block.

The watchdog is a two-state machine. In state `WD_IDLE` the counter is stopped. An arm access takes it to `WD_ARMED` and loads the timeout. In `WD_ARMED` an arm or feed access reloads the counter. A disarm access returns it to `WD_IDLE`. A line tick either decrements the counter or, if the count is already zero, raises the trap and returns the machine to `WD_IDLE`.

Top module: `addr_watch_monitor`

## Requirements
- R1: After reset `marker_pulse`, `log_en` and `trap` are 0, the watchdog is in `WD_IDLE`, and every tag entry is invalid, so no access has any effect.
- R2: A cycle with `tag_we` high writes entry `tag_idx` with `tag_addr`, `tag_act` and `tag_valid`. The write is seen by lookups from the next cycle onward. The action codes are: 1 marker, 2 log on, 3 log off, 4 arm, 5 feed, 6 disarm; 0 and 7 do nothing.
- R3: An access acts only when `bus_strobe` is high and `bus_addr` equals the address of a valid entry. Its effect shows on the outputs in the cycle after the access.
- R4: When several valid entries match one address, the entry with the lowest index decides the action.
- R5: A marker access makes `marker_pulse` high for exactly the one cycle after that access.
- R6: A log-on access sets `log_en` and a log-off access clears it. `log_en` holds its level otherwise.
- R7: An arm access loads `timeout_lines` as T. Starting from the arm or from the last feed, the first T line ticks pass without effect, and the tick after those sets `trap` in the following cycle. With T = 0, the first tick traps.
- R8: A feed access while armed reloads the count from `timeout_lines`. A feed while idle has no effect, so later ticks do not trap.
- R9: A disarm access stops the watchdog so that later ticks do not trap. It leaves an already raised `trap` set.
- R10: `trap` stays set until `trap_clr` is high. An expiry returns the watchdog to `WD_IDLE`, so no new trap follows without a new arm. If an expiry and a clear fall in the same cycle, the expiry wins.
- R11: When an arm, feed or disarm access coincides with a line tick, the access takes effect and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Snooped CPU address |
| bus_strobe | input | 1 | Qualifies `bus_addr` as a real access |
| line_tick | input | 1 | One-cycle pulse per scan line |
| tag_we | input | 1 | Tag table write enable |
| tag_idx | input | IDX_W | Entry to write |
| tag_addr | input | ADDR_W | Address to store in the entry |
| tag_act | input | 3 | Action code to store |
| tag_valid | input | 1 | Valid bit to store |
| timeout_lines | input | CNT_W | Timeout in lines, taken at arm and feed |
| trap_clr | input | 1 | Clears the trap flag |
| marker_pulse | output | 1 | One-cycle marker pulse |
| log_en | output | 1 | Trace logging enable level |
| trap | output | 1 | Sticky watchdog trap flag |

## Verification
The bench builds the block with 13 address bits, eight tags and an 8-bit counter. Random timeouts are kept between 0 and 7. This lets expiries, the zero-timeout case and feeds that land on the last allowed line all occur many times in a few thousand cycles. Eight entries are enough to hold duplicate addresses for the priority rule, plus entries with the unused codes 0 and 7. Random re-programming of the table also exercises a write and a lookup to the same entry in one cycle.

// File: rtl/awm_pkg.sv
package awm_pkg;
    typedef enum logic [2:0] {
        ACT_NOP     = 3'd0,
        ACT_MARK    = 3'd1,
        ACT_LOG_ON  = 3'd2,
        ACT_LOG_OFF = 3'd3,
        ACT_ARM     = 3'd4,
        ACT_FEED    = 3'd5,
        ACT_DISARM  = 3'd6,
        ACT_RSVD    = 3'd7
    } act_e;

    typedef enum logic {
        WD_IDLE  = 1'b0,
        WD_ARMED = 1'b1
    } wd_state_e;
endpackage

// File: rtl/awm_tag_table.sv
module awm_tag_table
    import awm_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int N_TAGS = 8,
    localparam int IDX_W = (N_TAGS > 1) ? $clog2(N_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [2:0]        wr_act,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_strobe,
    output act_e              hit_act
);
    logic [N_TAGS-1:0] valid_q;
    logic [ADDR_W-1:0] addr_q [N_TAGS];
    act_e              act_q  [N_TAGS];
    logic [N_TAGS-1:0] hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < N_TAGS; i++) begin
                addr_q[i] <= '0;
                act_q[i]  <= ACT_NOP;
            end
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
            addr_q[wr_idx]  <= wr_addr;
            act_q[wr_idx]   <= act_e'(wr_act);
        end
    end

    for (genvar g = 0; g < N_TAGS; g++) begin : g_cmp
        assign hit[g] = valid_q[g] && (addr_q[g] == bus_addr);
    end

    // Scan from the top so the lowest matching index is written last.
    always_comb begin
        hit_act = ACT_NOP;
        if (bus_strobe) begin
            for (int i = N_TAGS - 1; i >= 0; i--) begin
                if (hit[i]) hit_act = act_q[i];
            end
        end
    end
endmodule

// File: rtl/awm_trace_ctrl.sv
module awm_trace_ctrl
    import awm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  act_e act,
    output logic marker_pulse,
    output logic log_en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marker_pulse <= 1'b0;
            log_en       <= 1'b0;
        end else begin
            marker_pulse <= (act == ACT_MARK);
            if (act == ACT_LOG_ON)       log_en <= 1'b1;
            else if (act == ACT_LOG_OFF) log_en <= 1'b0;
        end
    end
endmodule

// File: rtl/awm_wd_fsm.sv
module awm_wd_fsm
    import awm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  act_e             act,
    input  logic             line_tick,
    input  logic [CNT_W-1:0] timeout_lines,
    input  logic             trap_clr,
    output logic             trap
);
    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             trap_q, trap_d;
    logic             expire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
            trap_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            trap_q  <= trap_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (act == ACT_ARM) begin
                    state_d = WD_ARMED;
                    cnt_d   = timeout_lines;
                end
            end
            WD_ARMED: begin
                if (act == ACT_ARM || act == ACT_FEED) begin
                    cnt_d = timeout_lines;
                end else if (act == ACT_DISARM) begin
                    state_d = WD_IDLE;
                end else if (line_tick) begin
                    if (cnt_q == '0) begin
                        state_d = WD_IDLE;
                        expire  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: state_d = WD_IDLE;
        endcase
        trap_d = expire ? 1'b1 : (trap_clr ? 1'b0 : trap_q);
    end

    assign trap = trap_q;
endmodule

// File: rtl/addr_watch_monitor.sv
module addr_watch_monitor
    import awm_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int N_TAGS = 8,
    parameter int CNT_W  = 16,
    localparam int IDX_W = (N_TAGS > 1) ? $clog2(N_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_strobe,
    input  logic              line_tick,
    input  logic              tag_we,
    input  logic [IDX_W-1:0]  tag_idx,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [2:0]        tag_act,
    input  logic              tag_valid,
    input  logic [CNT_W-1:0]  timeout_lines,
    input  logic              trap_clr,
    output logic              marker_pulse,
    output logic              log_en,
    output logic              trap
);
    act_e hit_act;

    awm_tag_table #(.ADDR_W(ADDR_W), .N_TAGS(N_TAGS)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tag_we), .wr_idx(tag_idx), .wr_addr(tag_addr),
        .wr_act(tag_act), .wr_valid(tag_valid),
        .bus_addr(bus_addr), .bus_strobe(bus_strobe),
        .hit_act(hit_act)
    );

    awm_trace_ctrl u_trace (
        .clk(clk), .rst_n(rst_n), .act(hit_act),
        .marker_pulse(marker_pulse), .log_en(log_en)
    );

    awm_wd_fsm #(.CNT_W(CNT_W)) u_wd (
        .clk(clk), .rst_n(rst_n), .act(hit_act),
        .line_tick(line_tick), .timeout_lines(timeout_lines),
        .trap_clr(trap_clr), .trap(trap)
    );
endmodule

// File: rtl/awm_checker.sv
module awm_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_strobe,
    input logic line_tick,
    input logic trap_clr,
    input logic marker_pulse,
    input logic log_en,
    input logic trap
);
    a_r5_marker_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> !marker_pulse);

    a_r6_log_holds_without_access: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> $stable(log_en));

    a_r7_trap_rises_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap && !line_tick) |=> !trap);

    a_r10_trap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && !trap_clr) |=> trap);

    a_r10_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && trap_clr && !line_tick) |=> !trap);
endmodule

bind addr_watch_monitor awm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .line_tick(line_tick),
    .trap_clr(trap_clr), .marker_pulse(marker_pulse), .log_en(log_en), .trap(trap)
);

// File: tb/tb_addr_watch_monitor.sv
module tb_addr_watch_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 13;
    localparam int N_TAGS = 8;
    localparam int CNT_W  = 8;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_strobe = 1'b0;
    logic              line_tick = 1'b0;
    logic              tag_we = 1'b0;
    logic [IDX_W-1:0]  tag_idx = '0;
    logic [ADDR_W-1:0] tag_addr = '0;
    logic [2:0]        tag_act = '0;
    logic              tag_valid = 1'b0;
    logic [CNT_W-1:0]  timeout_lines = '0;
    logic              trap_clr = 1'b0;
    logic              marker_pulse, log_en, trap;

    int tests = 0;
    int fails = 0;

    // Reference state
    logic              m_v [N_TAGS];
    logic [ADDR_W-1:0] m_a [N_TAGS];
    logic [2:0]        m_c [N_TAGS];
    logic              m_mark, m_log, m_trap, m_arm;
    int                m_cnt;

    addr_watch_monitor #(.ADDR_W(ADDR_W), .N_TAGS(N_TAGS), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
        .line_tick(line_tick), .tag_we(tag_we), .tag_idx(tag_idx),
        .tag_addr(tag_addr), .tag_act(tag_act), .tag_valid(tag_valid),
        .timeout_lines(timeout_lines), .trap_clr(trap_clr),
        .marker_pulse(marker_pulse), .log_en(log_en), .trap(trap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // R2/R4: lowest valid matching entry decides; codes 0 and 7 do nothing
    function automatic logic [2:0] lookup(input logic [ADDR_W-1:0] a);
        for (int i = 0; i < N_TAGS; i++)
            if (m_v[i] && m_a[i] == a) return m_c[i];
        return 3'd0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N_TAGS; i++) begin
            m_v[i] = 0; m_a[i] = '0; m_c[i] = '0;
        end
        m_mark = 0; m_log = 0; m_trap = 0; m_arm = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        logic [2:0] act;
        logic expire;
        act = bus_strobe ? lookup(bus_addr) : 3'd0;
        expire = 0;
        if (tag_we) begin
            m_v[tag_idx] = tag_valid; m_a[tag_idx] = tag_addr; m_c[tag_idx] = tag_act;
        end
        m_mark = (act == 3'd1);
        if (act == 3'd2) m_log = 1;
        else if (act == 3'd3) m_log = 0;
        if (act == 3'd4) begin
            m_arm = 1; m_cnt = int'(timeout_lines);
        end else if (act == 3'd6) begin
            m_arm = 0;
        end else if (act == 3'd5 && m_arm) begin
            m_cnt = int'(timeout_lines);
        end else if (m_arm && line_tick) begin
            if (m_cnt == 0) begin m_arm = 0; expire = 1; end
            else m_cnt--;
        end
        if (expire) m_trap = 1;
        else if (trap_clr) m_trap = 0;
    endtask

    task automatic check(input string req);
        tests++;
        if ({marker_pulse, log_en, trap} !== {m_mark, m_log, m_trap}) begin
            fails++;
            $display("FAIL %s: mark/log/trap actual %b%b%b expected %b%b%b",
                     req, marker_pulse, log_en, trap, m_mark, m_log, m_trap);
        end
    endtask

    task automatic cycle(input string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(req);
        bus_strobe = 0; line_tick = 0; tag_we = 0; trap_clr = 0;
    endtask

    task automatic prog(input int idx, input logic [ADDR_W-1:0] a, input logic [2:0] c,
                        input logic v);
        tag_we = 1; tag_idx = IDX_W'(idx); tag_addr = a; tag_act = c; tag_valid = v;
        cycle("R2");
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input logic tk, input string req);
        bus_addr = a; bus_strobe = 1; line_tick = tk;
        cycle(req);
    endtask

    task automatic ticks(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            line_tick = 1;
            cycle(req);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset state");
        access(13'h100, 0, "R1 no valid tags");
        access(13'h000, 1, "R1 no valid tags addr0");

        prog(0, 13'h100, 3'd1, 1);   // marker
        prog(1, 13'h200, 3'd2, 1);   // log on
        prog(2, 13'h201, 3'd3, 1);   // log off
        prog(3, 13'h300, 3'd4, 1);   // arm
        prog(4, 13'h301, 3'd5, 1);   // feed
        prog(5, 13'h302, 3'd6, 1);   // disarm
        prog(6, 13'h100, 3'd2, 1);   // duplicate of entry 0
        prog(7, 13'h400, 3'd7, 1);   // reserved code

        bus_addr = 13'h100; bus_strobe = 0; cycle("R3 no strobe");
        access(13'h101, 0, "R3 address miss");
        access(13'h100, 0, "R5 R4 marker wins over log on");
        cycle("R5 marker is one cycle");
        access(13'h400, 0, "R2 code 7 no action");
        access(13'h200, 0, "R6 log on");
        cycle("R6 log holds");
        access(13'h201, 0, "R6 log off");

        timeout_lines = 8'd4;
        access(13'h300, 0, "R7 arm");
        ticks(4, "R7 within budget");
        ticks(1, "R7 fifth line traps");
        ticks(3, "R10 idle after expiry");
        trap_clr = 1; cycle("R10 clear");

        access(13'h301, 0, "R8 feed while idle");
        ticks(6, "R8 no trap after idle feed");

        access(13'h300, 0, "R7 rearm");
        ticks(3, "R8 before feed");
        access(13'h301, 1, "R11 feed with tick");
        ticks(4, "R8 budget restarted");
        access(13'h302, 0, "R9 disarm");
        ticks(8, "R9 disarmed no trap");

        timeout_lines = 8'd0;
        access(13'h300, 1, "R11 arm with tick");
        ticks(1, "R7 zero timeout");
        access(13'h300, 0, "R7 arm again");
        access(13'h302, 0, "R9 disarm keeps trap");
        trap_clr = 1; line_tick = 1; cycle("R10 clear while idle");

        timeout_lines = 8'd1;
        access(13'h300, 0, "R7 arm t1");
        ticks(1, "R7 t1 first");
        trap_clr = 1; line_tick = 1; cycle("R10 expiry beats clear");

        prog(0, 13'h100, 3'd1, 0);
        access(13'h100, 0, "R2 invalidated entry falls to next");

        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 3) begin
                tag_we = 1; tag_idx = IDX_W'($urandom_range(0, N_TAGS-1));
                tag_addr = 13'h300 + ADDR_W'($urandom_range(0, 3));
                tag_act = 3'($urandom_range(0, 7));
                tag_valid = ($urandom_range(0, 4) != 0);
            end
            if (r < 60) begin
                bus_strobe = 1;
                bus_addr = ($urandom_range(0, 1) != 0) ? 13'h300 + ADDR_W'($urandom_range(0, 3))
                         : 13'h100 + ADDR_W'($urandom_range(0, 1)) * 13'h100
                           + ADDR_W'($urandom_range(0, 2));
            end
            line_tick = ($urandom_range(0, 2) == 0);
            trap_clr = ($urandom_range(0, 19) == 0);
            timeout_lines = CNT_W'($urandom_range(0, 7));
            cycle("R3 R7 R8 R9 R10 R11 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule